// File: doc/BRIEF.md
# I2C Master Byte Buffers with Burst Thresholds

This block sits between the register interface of an I2C master controller and its serial shift engine. It keeps one byte queue for outgoing data and one for incoming data, both of the same power-of-two depth. The host moves bytes through a single data register. A write to that register queues a byte for transmission. A read from it returns the oldest received byte and removes it. On the core side, the shift engine takes transmit bytes and deposits receive bytes through simple one-cycle pop and push strobes.

Data is handed to the host in bursts rather than byte by byte. The host loads a transfer length into a count register and sets a burst size for each direction. The block then raises a one-cycle "ready" event each time a full burst can be moved. When the bytes left in the transfer no longer fill a burst, it raises a "drain" event instead. For that final partial burst, the status register reports how many bytes are still to move. Each event fires once per burst and is not raised again until the host has moved that burst. Overflow and underflow events flag data-register accesses that the queues cannot serve.

The register port is a flat 2-bit word address: 0 buffer configuration, 1 buffer status, 2 data, 3 transfer count. Reads are combinational.

Top module: `i2c_fifo_buf`

## Requirements
- R1: After reset both queues are empty (`core_tx_avail` 0, `core_rx_room` 1), the configuration register reads 0 and no event output is high.
- R2: The configuration register holds the receive burst size minus one in bits 13:8 and the transmit burst size minus one in bits 5:0. Writing 1 to bit 14 empties the receive queue and writing 1 to bit 6 empties the transmit queue. Bits 15, 14, 7 and 6 always read 0. The effective burst size is the field plus one, capped at the queue depth.
- R3: Status bits 15:14 read the size code s, where depth = 8 << s. Bits 13:8 read the receive bytes still to move in the current drain burst, and bits 5:0 read the same for transmit. Each field is 0 when no drain burst is open.
- R4: Both queues deliver bytes in the order they were written. A data-register write (address 2) pushes bits 7:0. A data-register read returns the oldest receive byte in bits 7:0 and pops it.
- R5: A data-register write while the transmit queue is full pulses `ev_tx_ovf` for one cycle and leaves the queue contents unchanged.
- R6: A data-register read while the receive queue is empty pulses `ev_rx_udf` for one cycle and leaves the queue unchanged.
- R7: Writing the count register (address 3) sets the bytes remaining in each direction. `ev_tx_ready` pulses when no burst is open, at least one full burst remains to be sent, and the transmit queue has room for it.
- R8: `ev_tx_drain` pulses when no burst is open, fewer than a burst of bytes (but more than zero) remain to be sent, and they fit in the queue. Status bits 5:0 then count down from that number as the host writes.
- R9: `ev_rx_ready` pulses when no burst is open, at least one full burst remains to be read, and the receive queue holds a burst.
- R10: `ev_rx_drain` pulses when no burst is open, fewer than a burst (but more than zero) remain to be read, and the queue holds them all. Status bits 13:8 then count down as the host reads.
- R11: The clear bits empty their queue and close any open burst in that direction. The thresholds written in the same access take effect.
- R12: Each ready or drain event is a single-cycle pulse. It is not raised again for its direction until the host has moved every byte of the burst it announced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| core_tx_pop | input | 1 | Shift engine takes the head transmit byte |
| core_tx_avail | output | 1 | Transmit queue not empty |
| core_tx_byte | output | 8 | Head transmit byte |
| core_rx_push | input | 1 | Shift engine deposits a receive byte |
| core_rx_byte | input | 8 | Receive byte from the shift engine |
| core_rx_room | output | 1 | Receive queue not full |
| ev_tx_ready | output | 1 | Full transmit burst may be written |
| ev_tx_drain | output | 1 | Final partial transmit burst may be written |
| ev_rx_ready | output | 1 | Full receive burst may be read |
| ev_rx_drain | output | 1 | Final partial receive burst may be read |
| ev_tx_ovf | output | 1 | Write to a full transmit queue |
| ev_rx_udf | output | 1 | Read from an empty receive queue |

## Verification
On every cycle, the assertions check several properties. Occupancy stays within the depth. A rejected push or pop leaves the queue occupancy untouched, and a clear empties its queue. No event repeats on consecutive cycles. A ready event always coincides with room or data for a full burst, and a drain event only appears when less than a burst remains. The bench scenarios cover the rest: the byte order through each queue, the exact count of ready and drain events across a whole transfer, the countdown in the status fields, and the register read-back encodings.

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf #(
  parameter int SIZE_CODE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        core_tx_pop,
  output logic        core_tx_avail,
  output logic [7:0]  core_tx_byte,
  input  logic        core_rx_push,
  input  logic [7:0]  core_rx_byte,
  output logic        core_rx_room,
  output logic        ev_tx_ready,
  output logic        ev_tx_drain,
  output logic        ev_rx_ready,
  output logic        ev_rx_drain,
  output logic        ev_tx_ovf,
  output logic        ev_rx_udf
);
  localparam int DEPTH = 8 << SIZE_CODE;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [6:0]    DEPTH7 = 7'(DEPTH);
  localparam logic [CW-1:0] DEPTHC = CW'(DEPTH);

  logic [5:0]    tx_thr_m1, rx_thr_m1;
  logic [15:0]   xfer_len, tx_left, rx_left;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_burst, rx_burst;
  logic          tx_in_drain, rx_in_drain;

  wire cfg_wr    = reg_wr && reg_addr == 2'd0;
  wire clr_tx    = cfg_wr && reg_wdata[6];
  wire clr_rx    = cfg_wr && reg_wdata[14];
  wire host_push = reg_wr && reg_addr == 2'd2;
  wire host_pop  = reg_rd && reg_addr == 2'd2;
  wire cnt_wr    = reg_wr && reg_addr == 2'd3;
  wire quiet     = !reg_wr && !host_pop;

  wire tx_full  = tx_cnt == DEPTHC;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == DEPTHC;
  wire rx_empty = rx_cnt == '0;

  wire tx_push_ok = host_push && !tx_full;
  wire tx_pop_ok  = core_tx_pop && !tx_empty;
  wire rx_push_ok = core_rx_push && !rx_full;
  wire rx_pop_ok  = host_pop && !rx_empty;

  wire [6:0] tx_thr_raw = {1'b0, tx_thr_m1} + 7'd1;
  wire [6:0] rx_thr_raw = {1'b0, rx_thr_m1} + 7'd1;
  wire [CW-1:0] tx_thr = (tx_thr_raw > DEPTH7) ? DEPTHC : CW'(tx_thr_raw);
  wire [CW-1:0] rx_thr = (rx_thr_raw > DEPTH7) ? DEPTHC : CW'(rx_thr_raw);
  wire [CW-1:0] tx_space = DEPTHC - tx_cnt;

  wire tx_idle = quiet && tx_burst == '0 && tx_left != 16'd0;
  wire rx_idle = quiet && rx_burst == '0 && rx_left != 16'd0;
  wire tx_fire_rdy = tx_idle && tx_left >= 16'(tx_thr) && tx_space >= tx_thr;
  wire tx_fire_drn = tx_idle && tx_left < 16'(tx_thr) && 16'(tx_space) >= tx_left;
  wire rx_fire_rdy = rx_idle && rx_left >= 16'(rx_thr) && rx_cnt >= rx_thr;
  wire rx_fire_drn = rx_idle && rx_left < 16'(rx_thr) && 16'(rx_cnt) >= rx_left;

  assign core_tx_avail = !tx_empty;
  assign core_tx_byte  = tx_mem[tx_rp];
  assign core_rx_room  = !rx_full;

  always_ff @(posedge clk) begin
    if (tx_push_ok) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push_ok) rx_mem[rx_wp] <= core_rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_ok)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push_ok) - CW'(tx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_pop_ok)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push_ok) - CW'(rx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_m1 <= '0;
      rx_thr_m1 <= '0;
    end else if (cfg_wr) begin
      tx_thr_m1 <= reg_wdata[5:0];
      rx_thr_m1 <= reg_wdata[13:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_len <= '0; tx_left <= '0; tx_burst <= '0; tx_in_drain <= 1'b0;
    end else if (cnt_wr) begin
      xfer_len <= reg_wdata; tx_left <= reg_wdata;
      tx_burst <= '0; tx_in_drain <= 1'b0;
    end else begin
      if (tx_push_ok && tx_left != 16'd0) tx_left <= tx_left - 16'd1;
      if (clr_tx) begin
        tx_burst <= '0; tx_in_drain <= 1'b0;
      end else if (tx_fire_rdy) begin
        tx_burst <= tx_thr; tx_in_drain <= 1'b0;
      end else if (tx_fire_drn) begin
        tx_burst <= CW'(tx_left); tx_in_drain <= 1'b1;
      end else if (tx_push_ok && tx_burst != '0) begin
        tx_burst <= tx_burst - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_left <= '0; rx_burst <= '0; rx_in_drain <= 1'b0;
    end else if (cnt_wr) begin
      rx_left <= reg_wdata; rx_burst <= '0; rx_in_drain <= 1'b0;
    end else begin
      if (rx_pop_ok && rx_left != 16'd0) rx_left <= rx_left - 16'd1;
      if (clr_rx) begin
        rx_burst <= '0; rx_in_drain <= 1'b0;
      end else if (rx_fire_rdy) begin
        rx_burst <= rx_thr; rx_in_drain <= 1'b0;
      end else if (rx_fire_drn) begin
        rx_burst <= CW'(rx_left); rx_in_drain <= 1'b1;
      end else if (rx_pop_ok && rx_burst != '0) begin
        rx_burst <= rx_burst - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_tx_ready <= 1'b0; ev_tx_drain <= 1'b0;
      ev_rx_ready <= 1'b0; ev_rx_drain <= 1'b0;
      ev_tx_ovf <= 1'b0;   ev_rx_udf <= 1'b0;
    end else begin
      ev_tx_ready <= tx_fire_rdy;
      ev_tx_drain <= tx_fire_drn;
      ev_rx_ready <= rx_fire_rdy;
      ev_rx_drain <= rx_fire_drn;
      ev_tx_ovf   <= host_push && tx_full;
      ev_rx_udf   <= host_pop && rx_empty;
    end
  end

  wire [5:0] tx_drain_left = tx_in_drain ? 6'(tx_burst) : 6'd0;
  wire [5:0] rx_drain_left = rx_in_drain ? 6'(rx_burst) : 6'd0;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {2'b00, rx_thr_m1, 2'b00, tx_thr_m1};
      2'd1:    reg_rdata = {2'(SIZE_CODE), rx_drain_left, 2'b00, tx_drain_left};
      2'd2:    reg_rdata = {8'h00, rx_mem[rx_rp]};
      default: reg_rdata = xfer_len;
    endcase
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= DEPTHC && rx_cnt <= DEPTHC);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && tx_full && !core_tx_pop) |=> tx_cnt == $past(tx_cnt));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && rx_empty && !core_rx_push) |=> rx_cnt == '0);
  p_ready_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_ready |-> tx_space >= tx_thr);
  p_drain_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_drain |-> (tx_left < 16'(tx_thr) && tx_left != 16'd0));
  p_ready_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ready |-> rx_cnt >= rx_thr);
  p_drain_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_drain |-> (rx_left < 16'(rx_thr) && rx_left != 16'd0));
  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && clr_rx) |=> (tx_empty && rx_empty));
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_ready || ev_tx_drain) |=> !(ev_tx_ready || ev_tx_drain));
  p_single_pulse_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ready || ev_rx_drain) |=> !(ev_rx_ready || ev_rx_drain));
endmodule

// File: tb/i2c_fifo_buf_test.sv
module i2c_fifo_buf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic core_tx_pop = 1'b0, core_rx_push = 1'b0;
  logic [7:0] core_rx_byte = 8'h0;
  logic core_tx_avail, core_rx_room;
  logic [7:0] core_tx_byte;
  logic ev_tx_ready, ev_tx_drain, ev_rx_ready, ev_rx_drain, ev_tx_ovf, ev_rx_udf;

  int checks = 0, fails = 0;
  int n_txr = 0, n_txd = 0, n_rxr = 0, n_rxd = 0, n_ovf = 0, n_udf = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  i2c_fifo_buf uut (.*);

  always @(negedge clk) begin
    if (ev_tx_ready) n_txr++;
    if (ev_tx_drain) n_txd++;
    if (ev_rx_ready) n_rxr++;
    if (ev_rx_drain) n_rxd++;
    if (ev_tx_ovf)   n_ovf++;
    if (ev_rx_udf)   n_udf++;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic zero_counts();
    n_txr = 0; n_txd = 0; n_rxr = 0; n_rxd = 0; n_ovf = 0; n_udf = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic core_pop(output logic [7:0] b);
    @(negedge clk);
    b = core_tx_byte;
    core_tx_pop = 1'b1;
    @(negedge clk);
    core_tx_pop = 1'b0;
  endtask

  task automatic core_push(logic [7:0] b);
    @(negedge clk);
    core_rx_push = 1'b1; core_rx_byte = b;
    @(negedge clk);
    core_rx_push = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 tx empty", 16'(core_tx_avail), 16'd0);
    check("R1 rx room", 16'(core_rx_room), 16'd1);
    rd(2'd0, rv);
    check("R1 cfg zero", rv, 16'h0000);
    check("R1 no events", 16'(n_txr + n_txd + n_rxr + n_rxd + n_ovf + n_udf), 16'd0);
    rd(2'd1, rv);
    check("R3 size code", rv, 16'h4000);
  endtask

  task automatic t_config();
    wr(2'd0, 16'hFFFF);
    rd(2'd0, rv);
    check("R2 cfg readback", rv, 16'h3F3F);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_tx_bursts();
    logic [7:0] b;
    zero_counts();
    wr(2'd0, 16'h0003);
    wr(2'd3, 16'd10);
    idle(5);
    check("R7 first ready", 16'(n_txr), 16'd1);
    idle(5);
    check("R12 no repeat", 16'(n_txr), 16'd1);
    for (int i = 0; i < 4; i++) wr(2'd2, 16'(8'h10 + i));
    idle(3);
    check("R7 second ready", 16'(n_txr), 16'd2);
    for (int i = 4; i < 8; i++) wr(2'd2, 16'(8'h10 + i));
    idle(3);
    check("R8 drain fired", 16'(n_txd), 16'd1);
    check("R7 ready total", 16'(n_txr), 16'd2);
    rd(2'd1, rv);
    check("R8 status left 2", rv & 16'h003F, 16'd2);
    wr(2'd2, 16'h0018);
    rd(2'd1, rv);
    check("R8 status left 1", rv & 16'h003F, 16'd1);
    wr(2'd2, 16'h0019);
    idle(5);
    check("R12 drain once", 16'(n_txd), 16'd1);
    rd(2'd3, rv);
    check("R7 count readback", rv, 16'd10);
    for (int i = 0; i < 10; i++) begin
      core_pop(b);
      check("R4 tx order", 16'(b), 16'(8'h10 + i));
    end
    check("R4 tx empty after", 16'(core_tx_avail), 16'd0);
  endtask

  task automatic t_rx_bursts();
    zero_counts();
    wr(2'd0, 16'h0300);
    wr(2'd3, 16'd6);
    for (int i = 0; i < 3; i++) core_push(8'hA0 + 8'(i));
    idle(3);
    check("R9 no early ready", 16'(n_rxr), 16'd0);
    core_push(8'hA3);
    idle(3);
    check("R9 ready", 16'(n_rxr), 16'd1);
    for (int i = 0; i < 4; i++) begin
      rd(2'd2, rv);
      check("R4 rx order", rv, 16'(8'hA0 + i));
    end
    core_push(8'hA4);
    core_push(8'hA5);
    idle(3);
    check("R10 drain", 16'(n_rxd), 16'd1);
    rd(2'd1, rv);
    check("R10 status left 2", (rv >> 8) & 16'h003F, 16'd2);
    rd(2'd2, rv);
    check("R4 rx byte A4", rv, 16'h00A4);
    rd(2'd1, rv);
    check("R10 status left 1", (rv >> 8) & 16'h003F, 16'd1);
    rd(2'd2, rv);
    check("R4 rx byte A5", rv, 16'h00A5);
    idle(3);
    check("R12 rx events once", 16'(n_rxr + n_rxd), 16'd2);
  endtask

  task automatic t_underflow();
    zero_counts();
    rd(2'd2, rv);
    idle(2);
    check("R6 underflow", 16'(n_udf), 16'd1);
    core_push(8'h5C);
    rd(2'd2, rv);
    check("R6 contents kept", rv, 16'h005C);
    idle(2);
    check("R6 no extra", 16'(n_udf), 16'd1);
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    zero_counts();
    wr(2'd3, 16'd0);
    for (int i = 0; i < 17; i++) wr(2'd2, 16'(8'h20 + i));
    idle(2);
    check("R5 overflow", 16'(n_ovf), 16'd1);
    for (int i = 0; i < 16; i++) begin
      core_pop(b);
      check("R5 kept order", 16'(b), 16'(8'h20 + i));
    end
    check("R5 extra dropped", 16'(core_tx_avail), 16'd0);
  endtask

  task automatic t_flush();
    zero_counts();
    for (int i = 0; i < 3; i++) wr(2'd2, 16'h0077);
    core_push(8'h11);
    core_push(8'h12);
    check("R11 tx filled", 16'(core_tx_avail), 16'd1);
    wr(2'd0, 16'h4343);
    check("R11 tx cleared", 16'(core_tx_avail), 16'd0);
    rd(2'd0, rv);
    check("R2 clear bits read 0", rv, 16'h0303);
    rd(2'd2, rv);
    idle(2);
    check("R11 rx cleared", 16'(n_udf), 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_config();
    t_tx_bursts();
    t_rx_bursts();
    t_underflow();
    t_overflow();
    t_flush();
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule